// File: doc/BRIEF.md
# Paged Flash Erase Sequencer

This block turns one erase request into the series of serial-flash commands that carry it out. The request gives a byte offset and a byte length. The page size and the address shift of the attached device are static configuration inputs. The block first divides the offset and the length by the page size. If either one leaves a remainder, the block refuses the request. Otherwise it walks the range one step at a time. At each step it erases either one page or an aligned group of eight pages.

Every erase command is followed by status reads. The block reads the status repeatedly, with a fixed idle gap between reads, until the device reports ready. If the device is still not ready when the timeout window has passed, the block ends with a timeout error. The serial shifter itself lies outside the block and is reached through a byte exchange port. The block pulses `xferStart` with a byte to send. The port answers with `xferDone` and the byte it received, at least one cycle later. The block drives the active-low chip select around each command frame.

The two time intervals are given as clock-cycle counts (`TIMEOUT_CYC`, nominally two seconds, and `POLL_GAP_CYC`, nominally three milliseconds), so a simulation can scale them down.

Top module: `erase_seq`

## Requirements
- R1: If the offset or the length is not a whole multiple of `cfgPageSize`, the block ends with `errCode` = 1 and sends no frame.
- R2: An aligned request with zero length ends with `errCode` = 0 and sends no frame.
- R3: A step uses opcode 0x50 (eight-page erase) when the current page index has its three low bits at zero and at least eight pages remain. Every other step uses opcode 0x81 (single-page erase).
- R4: Each erase frame is exactly four bytes: the opcode, bits 23..16 of (page index << `cfgPageShift`), bits 15..8 of that value, and then 0x00.
- R5: Each status frame is exactly two bytes: 0xD7, then a dummy 0x00. Bit 7 of the byte received during the dummy byte means ready. The other status bits have no effect.
- R6: After a not-ready status, chip select stays high for at least `POLL_GAP_CYC` cycles before the next status frame. No further erase frame starts until a ready status has been seen.
- R7: A ready status after an eight-page erase advances the page index by 8 and lowers the remaining count by 8. After a single-page erase, both move by 1. The request ends with `errCode` = 0 once no pages remain.
- R8: If a status read is not ready and at least `TIMEOUT_CYC` cycles have passed since the erase frame ended, the block ends with `errCode` = 2 and sends no further frames. A ready status read in that same evaluation wins, and the sequence continues.
- R9: `busy` is high from the cycle after a request is taken until the cycle in which `done` pulses. `done` lasts one cycle. `errCode` is non-zero only while `done` is high. `reqValid` has no effect while `busy` is high.
- R10: `spiCsN` is low only while a frame is in progress and goes high between frames. `xferStart` is raised only while `spiCsN` is low, for a single cycle, and never while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start an erase request (taken when idle) |
| reqOffset | input | OFS_W | Byte offset of the range |
| reqLength | input | OFS_W | Byte length of the range |
| cfgPageSize | input | PSZ_W | Page size in bytes (non-zero, static) |
| cfgPageShift | input | SHF_W | Page index shift for the device address (static) |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| errCode | output | 2 | 0 ok, 1 misaligned, 2 timeout; valid with done |
| spiCsN | output | 1 | Active-low chip select |
| xferStart | output | 1 | Request one byte exchange |
| xferTxByte | output | 8 | Byte to send |
| xferDone | input | 1 | Byte exchange finished |
| xferRxByte | input | 8 | Byte received, valid with xferDone |

## Verification
The case of interest is a status read in which the device reports ready and the timeout window has already run out. Both the ready check and the timeout check are judged in the same evaluation cycle. To provoke it, one run keeps the device busy forever and counts how many status reads happen before the timeout error. A second run then lets the device turn ready on exactly that read. Since the cycle timing of the two runs is identical up to that point, the expiry coincides with the ready status. The second run is judged correct if it ends without error after the same number of reads.

// File: rtl/ers_pkg.sv
package ers_pkg;

  localparam logic [7:0] OP_ERASE_BLOCK = 8'h50;
  localparam logic [7:0] OP_ERASE_PAGE  = 8'h81;
  localparam logic [7:0] OP_STATUS_RD   = 8'hD7;
  localparam int         BLOCK_PAGES    = 8;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_ALIGN   = 2'd1,
    ERR_TIMEOUT = 2'd2
  } ersErr_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       capture;
    logic       divOff;
    logic       divLen;
    logic       latchStatus;
    logic       advance;
    logic       clrPollTmr;
    logic       clrWaitTmr;
    logic       pollPhase;
    logic [1:0] byteSel;
  } ersStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic divDone;
    logic misaligned;
    logic remZero;
    logic ready;
    logic timedOut;
    logic waitOver;
  } ersFlag_t;

endpackage

// File: rtl/ers_div.sv
module ers_div #(
  parameter int DVD_W = 32,
  parameter int DVS_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             done,
  output logic [DVD_W-1:0] quotient,
  output logic             remNz
);
  localparam int CNT_W = $clog2(DVD_W);

  logic [DVD_W-1:0] quo;
  logic [DVS_W:0]   rem;
  logic [DVS_W-1:0] dvs;
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic [DVS_W:0]   trial;
  logic             fits;

  assign trial = {rem[DVS_W-1:0], quo[DVD_W-1]};
  assign fits  = trial >= {1'b0, dvs};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quo  <= '0;
      rem  <= '0;
      dvs  <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        quo <= dividend;
        rem <= '0;
        dvs <= divisor;
        cnt <= CNT_W'(DVD_W - 1);
        run <= 1'b1;
      end else if (run) begin
        quo <= {quo[DVD_W-2:0], fits};
        rem <= fits ? (trial - {1'b0, dvs}) : trial;
        if (cnt == '0) begin
          run  <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign quotient = quo;
  assign remNz    = |rem;

endmodule

// File: rtl/ers_dp.sv
module ers_dp
  import ers_pkg::*;
#(
  parameter int OFS_W        = 32,
  parameter int PSZ_W        = 11,
  parameter int SHF_W        = 4,
  parameter int TIMEOUT_CYC  = 500_000_000,
  parameter int POLL_GAP_CYC = 750_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFS_W-1:0] reqOffset,
  input  logic [OFS_W-1:0] reqLength,
  input  logic [PSZ_W-1:0] cfgPageSize,
  input  logic [SHF_W-1:0] cfgPageShift,
  input  ersStrobe_t       st,
  input  logic [7:0]       xferRxByte,
  output ersFlag_t         fl,
  output logic [7:0]       txByte
);
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
  localparam int GAP_W = $clog2(POLL_GAP_CYC + 1);
  localparam logic [TMR_W-1:0] TMR_MAX = TMR_W'(TIMEOUT_CYC);
  localparam logic [GAP_W-1:0] GAP_END = GAP_W'(POLL_GAP_CYC - 1);
  localparam logic [OFS_W-1:0] BLK_STEP = OFS_W'(BLOCK_PAGES);

  logic [OFS_W-1:0] capOff, capLen;
  logic [OFS_W-1:0] pageIdx, remPages;
  logic             offNz, lenNz, selLen, readyBit;
  logic [TMR_W-1:0] pollTmr;
  logic [GAP_W-1:0] waitTmr;
  logic             divStart, divDone, divRemNz;
  logic [OFS_W-1:0] divQuo, divIn;
  logic             doBlock;
  logic [15:0]      addrHi;
  logic [7:0]       cmdOp;
  logic [6:0]       unusedStatusBits;

  assign unusedStatusBits = xferRxByte[6:0];

  assign divStart = st.divOff | st.divLen;
  assign divIn    = st.divLen ? capLen : capOff;

  ers_div #(.DVD_W(OFS_W), .DVS_W(PSZ_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (divStart),
    .dividend (divIn),
    .divisor  (cfgPageSize),
    .done     (divDone),
    .quotient (divQuo),
    .remNz    (divRemNz)
  );

  assign doBlock = (pageIdx[2:0] == 3'b000) && (remPages >= BLK_STEP);
  assign addrHi  = 16'((pageIdx << cfgPageShift) >> 8);
  assign cmdOp   = doBlock ? OP_ERASE_BLOCK : OP_ERASE_PAGE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      capOff   <= '0;
      capLen   <= '0;
      pageIdx  <= '0;
      remPages <= '0;
      offNz    <= 1'b0;
      lenNz    <= 1'b0;
      selLen   <= 1'b0;
      readyBit <= 1'b0;
    end else begin
      if (st.capture) begin
        capOff <= reqOffset;
        capLen <= reqLength;
      end
      if (st.divOff) selLen <= 1'b0;
      if (st.divLen) selLen <= 1'b1;
      if (divDone) begin
        if (selLen) begin
          remPages <= divQuo;
          lenNz    <= divRemNz;
        end else begin
          pageIdx <= divQuo;
          offNz   <= divRemNz;
        end
      end
      if (st.advance) begin
        if (doBlock) begin
          pageIdx  <= pageIdx + BLK_STEP;
          remPages <= remPages - BLK_STEP;
        end else begin
          pageIdx  <= pageIdx + 1'b1;
          remPages <= remPages - 1'b1;
        end
      end
      if (st.latchStatus) readyBit <= xferRxByte[7];
    end
  end

  // cycles since the erase frame ended, saturating
  always_ff @(posedge clk) begin
    if (!rst_n || st.clrPollTmr) pollTmr <= '0;
    else if (pollTmr != TMR_MAX) pollTmr <= pollTmr + 1'b1;
  end

  // idle gap between status frames
  always_ff @(posedge clk) begin
    if (!rst_n || st.clrWaitTmr) waitTmr <= '0;
    else if (waitTmr != GAP_END) waitTmr <= waitTmr + 1'b1;
  end

  always_comb begin
    if (st.pollPhase) begin
      txByte = (st.byteSel == 2'd0) ? OP_STATUS_RD : 8'h00;
    end else begin
      case (st.byteSel)
        2'd0:    txByte = cmdOp;
        2'd1:    txByte = addrHi[15:8];
        2'd2:    txByte = addrHi[7:0];
        default: txByte = 8'h00;
      endcase
    end
  end

  assign fl.divDone    = divDone;
  assign fl.misaligned = offNz | lenNz;
  assign fl.remZero    = (remPages == '0);
  assign fl.ready      = readyBit;
  assign fl.timedOut   = (pollTmr >= TMR_MAX);
  assign fl.waitOver   = (waitTmr == GAP_END);

endmodule

// File: rtl/ers_ctl.sv
module ers_ctl
  import ers_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  ersFlag_t   fl,
  input  logic       xferDone,
  output ersStrobe_t st,
  output logic       xferStart,
  output logic       spiCsN,
  output logic       busy,
  output logic       done,
  output logic [1:0] errCode
);
  typedef enum logic [3:0] {
    S_IDLE, S_DOFF, S_DOFF_W, S_DLEN, S_DLEN_W, S_CHECK,
    S_CSEND, S_CWAIT, S_CEND, S_PSEND, S_PWAIT, S_PEVAL,
    S_PGAP, S_NEXT, S_FIN
  } ctlState_e;

  ctlState_e state, nxt;
  logic [1:0] byteIdx;
  ersErr_e    errReg;

  always_comb begin
    nxt          = state;
    st           = '0;
    st.byteSel   = byteIdx;
    st.pollPhase = (state == S_PSEND) || (state == S_PWAIT);
    case (state)
      S_IDLE: if (reqValid) begin
        st.capture = 1'b1;
        nxt        = S_DOFF;
      end
      S_DOFF: begin
        st.divOff = 1'b1;
        nxt       = S_DOFF_W;
      end
      S_DOFF_W: if (fl.divDone) nxt = S_DLEN;
      S_DLEN: begin
        st.divLen = 1'b1;
        nxt       = S_DLEN_W;
      end
      S_DLEN_W: if (fl.divDone) nxt = S_CHECK;
      S_CHECK: nxt = (fl.misaligned || fl.remZero) ? S_FIN : S_CSEND;
      S_CSEND: nxt = S_CWAIT;
      S_CWAIT: if (xferDone) begin
        if (byteIdx == 2'd3) begin
          st.clrPollTmr = 1'b1;
          nxt           = S_CEND;
        end else begin
          nxt = S_CSEND;
        end
      end
      S_CEND:  nxt = S_PSEND;
      S_PSEND: nxt = S_PWAIT;
      S_PWAIT: if (xferDone) begin
        if (byteIdx == 2'd1) begin
          st.latchStatus = 1'b1;
          nxt            = S_PEVAL;
        end else begin
          nxt = S_PSEND;
        end
      end
      S_PEVAL: begin
        if (fl.ready) begin
          st.advance = 1'b1;
          nxt        = S_NEXT;
        end else if (fl.timedOut) begin
          nxt = S_FIN;
        end else begin
          st.clrWaitTmr = 1'b1;
          nxt           = S_PGAP;
        end
      end
      S_PGAP:  if (fl.waitOver) nxt = S_PSEND;
      S_NEXT:  nxt = fl.remZero ? S_FIN : S_CSEND;
      S_FIN:   nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      byteIdx <= 2'd0;
      errReg  <= ERR_NONE;
    end else begin
      state <= nxt;
      case (state)
        S_CHECK: begin
          byteIdx <= 2'd0;
          errReg  <= fl.misaligned ? ERR_ALIGN : ERR_NONE;
        end
        S_CWAIT: if (xferDone) byteIdx <= byteIdx + 2'd1;
        S_CEND:  byteIdx <= 2'd0;
        S_PWAIT: if (xferDone) byteIdx <= (byteIdx == 2'd1) ? 2'd0 : 2'd1;
        S_PEVAL: begin
          byteIdx <= 2'd0;
          if (!fl.ready && fl.timedOut) errReg <= ERR_TIMEOUT;
        end
        S_NEXT:  byteIdx <= 2'd0;
        default: ;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FIN);
  assign errCode   = done ? errReg : ERR_NONE;
  assign xferStart = (state == S_CSEND) || (state == S_PSEND);
  assign spiCsN    = !((state == S_CSEND) || (state == S_CWAIT) ||
                       (state == S_PSEND) || (state == S_PWAIT));

endmodule

// File: rtl/erase_seq.sv
module erase_seq
  import ers_pkg::*;
#(
  parameter int OFS_W        = 32,
  parameter int PSZ_W        = 11,
  parameter int SHF_W        = 4,
  parameter int TIMEOUT_CYC  = 500_000_000,
  parameter int POLL_GAP_CYC = 750_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic [OFS_W-1:0] reqOffset,
  input  logic [OFS_W-1:0] reqLength,
  input  logic [PSZ_W-1:0] cfgPageSize,
  input  logic [SHF_W-1:0] cfgPageShift,
  output logic             busy,
  output logic             done,
  output logic [1:0]       errCode,
  output logic             spiCsN,
  output logic             xferStart,
  output logic [7:0]       xferTxByte,
  input  logic             xferDone,
  input  logic [7:0]       xferRxByte
);
  ersStrobe_t st;
  ersFlag_t   fl;

  ers_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqValid  (reqValid),
    .fl        (fl),
    .xferDone  (xferDone),
    .st        (st),
    .xferStart (xferStart),
    .spiCsN    (spiCsN),
    .busy      (busy),
    .done      (done),
    .errCode   (errCode)
  );

  ers_dp #(
    .OFS_W        (OFS_W),
    .PSZ_W        (PSZ_W),
    .SHF_W        (SHF_W),
    .TIMEOUT_CYC  (TIMEOUT_CYC),
    .POLL_GAP_CYC (POLL_GAP_CYC)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .reqOffset    (reqOffset),
    .reqLength    (reqLength),
    .cfgPageSize  (cfgPageSize),
    .cfgPageShift (cfgPageShift),
    .st           (st),
    .xferRxByte   (xferRxByte),
    .fl           (fl),
    .txByte       (xferTxByte)
  );

endmodule

// File: rtl/ers_seq_chk.sv
module ers_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic [1:0] errCode,
  input logic       spiCsN,
  input logic       xferStart
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                          // R9
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);                                          // R9
  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);                                // R9
  AST_ERR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (errCode != 2'd3));                              // R9
  AST_START_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    xferStart |-> !spiCsN);                                   // R10
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    xferStart |=> !xferStart);                                // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (spiCsN && !xferStart));                        // R10
endmodule

bind erase_seq ers_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .errCode   (errCode),
  .spiCsN    (spiCsN),
  .xferStart (xferStart)
);

// File: tb/erase_seq_tb.sv
module erase_seq_tb;
  localparam int TMO = 300;
  localparam int GAP = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqOffset = '0;
  logic [31:0] reqLength = '0;
  logic [10:0] cfgPageSize = 11'd264;
  logic [3:0]  cfgPageShift = 4'd9;
  logic        busy, done, spiCsN, xferStart;
  logic [1:0]  errCode;
  logic [7:0]  xferTxByte;
  logic        xferDone;
  logic [7:0]  xferRxByte;

  always #2 clk = ~clk;

  erase_seq #(.TIMEOUT_CYC(TMO), .POLL_GAP_CYC(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOffset(reqOffset),
    .reqLength(reqLength), .cfgPageSize(cfgPageSize), .cfgPageShift(cfgPageShift),
    .busy(busy), .done(done), .errCode(errCode), .spiCsN(spiCsN),
    .xferStart(xferStart), .xferTxByte(xferTxByte), .xferDone(xferDone),
    .xferRxByte(xferRxByte)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // ---------------- device model ----------------
  int         busyCfg = 0;
  int         busyLeft = 0;
  int         pollCount = 0;
  int         nErase = 0;
  int         nPollBad = 0;
  int         earlyErase = 0;
  int         gapViol = 0;
  int         fIdx = 0;
  int         gapCnt = 0;
  bit         lastBusy = 0;
  bit         prevCs = 1;
  int         pend = 0;
  logic [7:0] replyReg = 8'hFF;
  logic [7:0] fb [4];
  logic [7:0] logOp [64];
  logic [7:0] logB1 [64];
  logic [7:0] logB2 [64];
  logic [7:0] logB3 [64];
  int         logLen [64];

  initial begin
    xferDone = 1'b0;
    xferRxByte = 8'h00;
  end

  always @(posedge clk) begin
    xferDone <= 1'b0;
    if (pend != 0) begin
      pend <= pend - 1;
      if (pend == 1) begin
        xferDone   <= 1'b1;
        xferRxByte <= replyReg;
      end
    end
    prevCs <= spiCsN;
    if (spiCsN) gapCnt <= gapCnt + 1; else gapCnt <= 0;
    if (!spiCsN && prevCs && lastBusy && gapCnt < GAP) gapViol <= gapViol + 1;
    if (xferStart) begin
      pend <= 3;
      if (fIdx < 4) fb[fIdx] <= xferTxByte;
      if (fIdx == 0 && xferTxByte != 8'hD7 && busyLeft > 0) earlyErase <= earlyErase + 1;
      if (fIdx == 1 && fb[0] == 8'hD7) begin
        pollCount <= pollCount + 1;
        if (busyLeft > 0) begin
          replyReg <= 8'h3C;   // ready clear, other bits set
          busyLeft <= busyLeft - 1;
          lastBusy <= 1'b1;
        end else begin
          replyReg <= 8'hBC;
          lastBusy <= 1'b0;
        end
      end else begin
        replyReg <= 8'hFF;
      end
      fIdx <= fIdx + 1;
    end
    if (spiCsN && !prevCs) begin
      if (fb[0] == 8'hD7) begin
        if (fIdx != 2 || fb[1] != 8'h00) nPollBad <= nPollBad + 1;
      end else begin
        if (nErase < 64) begin
          logOp[nErase]  <= fb[0];
          logB1[nErase]  <= fb[1];
          logB2[nErase]  <= fb[2];
          logB3[nErase]  <= fb[3];
          logLen[nErase] <= fIdx;
        end
        nErase   <= nErase + 1;
        busyLeft <= busyCfg;
        lastBusy <= 1'b0;
      end
      fIdx <= 0;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++;
      bad++;
      $display("FAIL R9 watchdog act=%0d exp=%0d", cycles, 150000);
      summary();
    end
  end

  int expN;
  int expOp [64];
  int expB1 [64];
  int expB2 [64];

  task automatic buildExp(input longint ofs, input longint len, input int psz, input int sh);
    longint idx = ofs / psz;
    longint rem = len / psz;
    expN = 0;
    while (rem > 0 && expN < 64) begin
      bit blk = (idx % 8 == 0) && (rem >= 8);
      longint a = idx << sh;
      expOp[expN] = blk ? 'h50 : 'h81;
      expB1[expN] = int'((a >> 16) & 255);
      expB2[expN] = int'((a >> 8) & 255);
      expN++;
      if (blk) begin idx += 8; rem -= 8; end
      else begin idx += 1; rem -= 1; end
    end
  endtask

  task automatic runOp(input longint ofs, input longint len, input int psz, input int sh,
                       input int bp, input bit poke, output int err, output bit busyHole);
    int cyc = 0;
    busyCfg = bp; busyLeft = 0; pollCount = 0; nErase = 0;
    nPollBad = 0; earlyErase = 0; gapViol = 0; lastBusy = 0;
    busyHole = 0;
    cfgPageSize = 11'(psz); cfgPageShift = 4'(sh);
    @(negedge clk);
    reqOffset = 32'(ofs); reqLength = 32'(len); reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (!done && cyc < 40000) begin
      if (!busy) busyHole = 1;
      if (poke && cyc == 40) begin
        reqValid = 1'b1; reqOffset = 32'd0; reqLength = 32'(psz * 16);
      end else begin
        reqValid = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    reqValid = 1'b0;
    err = done ? int'(errCode) : -1;
    @(negedge clk);
    chk(!done && !busy, "R9 done one cycle then idle", {done, busy}, 0);
  endtask

  task automatic checkFrames(input string tag);
    chk(nErase == expN, {tag, " R7 erase count"}, nErase, expN);
    for (int i = 0; i < expN && i < nErase; i++) begin
      chk(logOp[i] == expOp[i], {tag, " R3 opcode"}, logOp[i], expOp[i]);
      chk(logB1[i] == expB1[i] && logB2[i] == expB2[i], {tag, " R4 address"},
          {logB1[i], logB2[i]}, {expB1[i][7:0], expB2[i][7:0]});
      chk(logB3[i] == 8'h00 && logLen[i] == 4, {tag, " R4 frame tail/len"}, logLen[i], 4);
    end
    chk(nPollBad == 0, {tag, " R5 status frame form"}, nPollBad, 0);
    chk(earlyErase == 0, {tag, " R6 erase while busy"}, earlyErase, 0);
    chk(gapViol == 0, {tag, " R6 poll gap"}, gapViol, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic tReset();
    chk(!busy && !done && spiCsN && !xferStart, "R10 reset idle", {busy, done, spiCsN}, 3'b001);
  endtask

  task automatic tMixed();
    int e; bit h;
    buildExp(6 * 264, 12 * 264, 264, 9);
    runOp(6 * 264, 12 * 264, 264, 9, 0, 1, e, h);
    chk(e == 0, "R7 mixed ends ok", e, 0);
    chk(!h, "R9 busy held, poke ignored", h, 0);
    checkFrames("mixed");
    chk(pollCount == expN, "R5 one poll per step when ready", pollCount, expN);
  endtask

  task automatic tBlocksBusy();
    int e; bit h;
    buildExp(0, 16 * 528, 528, 10);
    runOp(0, 16 * 528, 528, 10, 2, 0, e, h);
    chk(e == 0, "R3 two blocks ok", e, 0);
    checkFrames("blocks");
    chk(pollCount == expN * 3, "R6 repoll until ready", pollCount, expN * 3);
  endtask

  task automatic tHighAddr();
    int e; bit h;
    buildExp(4096 * 1056, 7 * 1056, 1056, 11);
    runOp(4096 * 1056, 7 * 1056, 1056, 11, 1, 0, e, h);
    chk(e == 0, "R3 short tail pages ok", e, 0);
    checkFrames("high");
  endtask

  task automatic tMisaligned();
    int e; bit h;
    runOp(264 + 4, 264, 264, 9, 0, 0, e, h);
    chk(e == 1, "R1 offset misaligned", e, 1);
    chk(nErase == 0 && pollCount == 0, "R1 no frame", nErase, 0);
    runOp(264, 2 * 264 + 1, 264, 9, 0, 0, e, h);
    chk(e == 1, "R1 length misaligned", e, 1);
    chk(nErase == 0 && pollCount == 0, "R1 no frame len", nErase, 0);
  endtask

  task automatic tZero();
    int e; bit h;
    runOp(8 * 264, 0, 264, 9, 0, 0, e, h);
    chk(e == 0, "R2 zero length ok", e, 0);
    chk(nErase == 0 && pollCount == 0, "R2 no frame", nErase, 0);
  endtask

  task automatic tTimeoutAndRace();
    int e; bit h; int n;
    runOp(3 * 264, 2 * 264, 264, 9, 100000, 0, e, h);
    n = pollCount;
    chk(e == 2, "R8 timeout error", e, 2);
    chk(nErase == 1, "R8 no further erase", nErase, 1);
    chk(n > 1, "R8 polled several times", n, 2);
    runOp(3 * 264, 264, 264, 9, n - 1, 0, e, h);
    chk(e == 0, "R8 ready wins at expiry", e, 0);
    chk(pollCount == n, "R8 same poll count", pollCount, n);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    tReset();
    rst_n = 1'b1;
    @(negedge clk);
    tReset();
    tMixed();
    tBlocksBusy();
    tHighAddr();
    tMisaligned();
    tZero();
    tTimeoutAndRace();
    summary();
  end

endmodule